// File: doc/BRIEF.md
# Channel Engage and Health Supervisor

This block judges whether one channel of a dual-processor flight control computer may command its actuators. It watches two processor failure lines, a watchdog kick, an overvoltage flag and the pilot's ON/OFF pushbutton. From these it produces a healthy discrete and a master relay enable. The master enable is the single switch that feeds power to every other output relay of the channel.

A failure line counts only after it has stayed high for a set number of clocks. A confirmed failure, a missed watchdog kick or an overvoltage is then held in a latch. The moment any of these faults is detected, the block sends a processor reset pulse of fixed length, forces its internal switch state to OFF and lights the fault lamp. The fault lamp stays lit while any latch is set.

The only way back is for the pilot to cycle the pushbutton OFF and then ON while all three raw fault inputs are low. Either processor can also open the relays on its own through a direct open request, and this takes effect without going through the health decision.

Top module: `chan_engage_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, healthy_o, relay_en_o, cpu_rst_o and lamp_fault_o are 0 and lamp_off_o is 1.
- R2: On a clock edge that sees pb_on_i at 1 after a cycle at 0, with main_fail_i, servo_fail_i and overvolt_i all 0, the switch state turns ON. From the next cycle healthy_o is 1 and lamp_off_o is 0, provided no fault latch is set.
- R3: A processor failure line (main_fail_i or servo_fail_i) latches only after CONFIRM_CYC consecutive clock edges at 1. A shorter burst leaves healthy_o at 1 and lamp_fault_o at 0.
- R4: The watchdog latches a fault after WD_TIMEOUT consecutive clock edges with wd_kick_i at 0. Each kick restarts this count from zero.
- R5: overvolt_i latches a fault on the first clock edge that sees it at 1.
- R6: On the cycle a new fault latch becomes visible, lamp_fault_o is 1, healthy_o is 0 and lamp_off_o is 1. The switch state has been forced OFF.
- R7: A newly detected fault raises cpu_rst_o for exactly RST_CYC cycles, starting on the cycle the latch becomes visible. A fault that is already latched does not restart the pulse.
- R8: Fault latches clear only on an OFF-to-ON press with all raw fault inputs at 0. Releasing the button does not clear them. Pressing ON while a raw failure input is high does not clear them either.
- R9: A clock edge that sees pb_on_i at 0 turns the switch state OFF. From the next cycle healthy_o is 0 and lamp_off_o is 1.
- R10: relay_en_o is healthy_o gated combinationally by main_open_i and servo_open_i. Either open request alone forces relay_en_o to 0 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_fail_i | input | 1 | Main processor failure line |
| servo_fail_i | input | 1 | Servo-loop processor failure line |
| wd_kick_i | input | 1 | Watchdog kick, one pulse per service |
| overvolt_i | input | 1 | Overvoltage detected |
| pb_on_i | input | 1 | Pushbutton level, 1 = ON selected |
| main_open_i | input | 1 | Main processor request to open relays |
| servo_open_i | input | 1 | Servo processor request to open relays |
| healthy_o | output | 1 | Channel healthy discrete |
| relay_en_o | output | 1 | Master relay power enable |
| cpu_rst_o | output | 1 | Processor reset pulse |
| lamp_fault_o | output | 1 | Fault lamp, lit while any fault is latched |
| lamp_off_o | output | 1 | OFF indication, lit while the switch state is OFF |

## Verification
The assertions assume that every input is synchronous to clk and held steady across each rising edge. The kick is treated as a level sampled once per edge, not as an edge event. The bench meets this by changing inputs only on the falling edge. The failure lines are driven as random bursts of varying length, so runs both shorter and longer than the confirmation window occur. Long gaps without a kick, pushbutton cycles with and without a raw failure present, and relay-open requests that arrive in isolation are covered by directed sequences.

// File: rtl/chan_engage_ctrl.sv
module chan_engage_ctrl #(
  parameter int CONFIRM_CYC = 4,
  parameter int WD_TIMEOUT  = 32,
  parameter int RST_CYC     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic main_fail_i,
  input  logic servo_fail_i,
  input  logic wd_kick_i,
  input  logic overvolt_i,
  input  logic pb_on_i,
  input  logic main_open_i,
  input  logic servo_open_i,
  output logic healthy_o,
  output logic relay_en_o,
  output logic cpu_rst_o,
  output logic lamp_fault_o,
  output logic lamp_off_o
);
  localparam int CW = $clog2(CONFIRM_CYC + 1);
  localparam int WW = $clog2(WD_TIMEOUT + 1);
  localparam int RW = $clog2(RST_CYC + 1);
  localparam logic [CW-1:0] C_LAST = CW'(CONFIRM_CYC - 1);
  localparam logic [WW-1:0] W_LAST = WW'(WD_TIMEOUT - 1);
  localparam logic [RW-1:0] R_LEN  = RW'(RST_CYC);

  logic [1:0]    pf_raw, pf_lat, pf_set;
  logic [CW-1:0] pf_cnt [2];
  logic [WW-1:0] wd_cnt;
  logic [RW-1:0] rst_cnt;
  logic          wd_lat, ov_lat, sw_on, pb_q;

  assign pf_raw = {servo_fail_i, main_fail_i};

  wire pb_rise  = pb_on_i & ~pb_q;
  wire rearm    = pb_rise & ~(|pf_raw) & ~overvolt_i;
  wire wd_set   = ~wd_kick_i & (wd_cnt == W_LAST) & ~wd_lat;
  wire ov_set   = overvolt_i & ~ov_lat;
  wire new_fail = ((|pf_set) | wd_set | ov_set) & ~rearm;
  wire any_lat  = (|pf_lat) | wd_lat | ov_lat;

  for (genvar i = 0; i < 2; i++) begin : g_pf
    assign pf_set[i] = pf_raw[i] & (pf_cnt[i] == C_LAST) & ~pf_lat[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pf_cnt[i] <= '0;
        pf_lat[i] <= 1'b0;
      end else begin
        if (!pf_raw[i])
          pf_cnt[i] <= '0;
        else if (pf_cnt[i] != C_LAST)
          pf_cnt[i] <= pf_cnt[i] + 1'b1;
        if (rearm)
          pf_lat[i] <= 1'b0;
        else if (pf_set[i])
          pf_lat[i] <= 1'b1;
      end
    end

    p_confirm_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pf_lat[i]) |-> $past(pf_raw[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_cnt  <= '0;
      wd_lat  <= 1'b0;
      ov_lat  <= 1'b0;
      sw_on   <= 1'b0;
      pb_q    <= 1'b0;
      rst_cnt <= '0;
    end else begin
      if (rearm || wd_kick_i)
        wd_cnt <= '0;
      else if (wd_cnt != W_LAST)
        wd_cnt <= wd_cnt + 1'b1;

      if (rearm)       wd_lat <= 1'b0;
      else if (wd_set) wd_lat <= 1'b1;

      if (rearm)           ov_lat <= 1'b0;
      else if (overvolt_i) ov_lat <= 1'b1;

      if (rearm)                     sw_on <= 1'b1;
      else if (!pb_on_i || new_fail) sw_on <= 1'b0;

      pb_q <= pb_on_i;

      if (new_fail)            rst_cnt <= R_LEN;
      else if (rst_cnt != '0)  rst_cnt <= rst_cnt - 1'b1;
    end
  end

  assign healthy_o    = sw_on & ~any_lat;
  assign relay_en_o   = healthy_o & ~main_open_i & ~servo_open_i;
  assign cpu_rst_o    = (rst_cnt != '0);
  assign lamp_fault_o = any_lat;
  assign lamp_off_o   = ~sw_on;

  p_wd_no_kick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_lat) |-> !$past(wd_kick_i));

  p_ov_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    overvolt_i |=> lamp_fault_o);

  p_detect_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lamp_fault_o) |-> !healthy_o && lamp_off_o);

  p_detect_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lamp_fault_o) |-> cpu_rst_o);

  p_clear_press_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lamp_fault_o) |-> $past(pb_on_i) && !$past(pb_q) && !$past(main_fail_i)
                            && !$past(servo_fail_i) && !$past(overvolt_i));

  p_off_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pb_on_i |=> !healthy_o);

  p_open_cuts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (main_open_i || servo_open_i) |-> !relay_en_o);
endmodule

// File: tb/chan_engage_ctrl_tb.sv
module chan_engage_ctrl_tb;
  localparam int CONF = 4;
  localparam int WD   = 32;
  localparam int RST  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mf = 0, sf = 0, ov = 0, kick = 0, pb = 0, mo = 0, so = 0;
  logic healthy, relay, cpu_rst, lfault, loff;

  int n_chk = 0, n_fail = 0;
  bit auto_kick = 1'b1;
  int kph = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  chan_engage_ctrl #(.CONFIRM_CYC(CONF), .WD_TIMEOUT(WD), .RST_CYC(RST)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .main_fail_i(mf), .servo_fail_i(sf), .wd_kick_i(kick), .overvolt_i(ov),
    .pb_on_i(pb), .main_open_i(mo), .servo_open_i(so),
    .healthy_o(healthy), .relay_en_o(relay), .cpu_rst_o(cpu_rst),
    .lamp_fault_o(lfault), .lamp_off_o(loff));

  int m_mrun = 0, m_srun = 0, m_widle = 0, m_rleft = 0;
  bit m_ml = 0, m_sl = 0, m_wl = 0, m_ol = 0, m_sw = 0, m_pbq = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mrun = 0; m_srun = 0; m_widle = 0; m_rleft = 0;
      m_ml = 0; m_sl = 0; m_wl = 0; m_ol = 0; m_sw = 0; m_pbq = 0;
    end else begin
      bit clr, nm, ns, nw, no, newf;
      clr = pb && !m_pbq && !mf && !sf && !ov;
      m_mrun  = mf ? m_mrun + 1 : 0;
      m_srun  = sf ? m_srun + 1 : 0;
      m_widle = (kick || clr) ? 0 : m_widle + 1;
      nm = m_ml || (m_mrun >= CONF);
      ns = m_sl || (m_srun >= CONF);
      nw = m_wl || (m_widle >= WD);
      no = m_ol || ov;
      newf = !clr && ((nm && !m_ml) || (ns && !m_sl) || (nw && !m_wl) || (no && !m_ol));
      if (clr) begin m_ml = 0; m_sl = 0; m_wl = 0; m_ol = 0; end
      else begin m_ml = nm; m_sl = ns; m_wl = nw; m_ol = no; end
      if (clr) m_sw = 1;
      else if (!pb || newf) m_sw = 0;
      m_rleft = newf ? RST : (m_rleft > 0 ? m_rleft - 1 : 0);
      m_pbq = pb;
    end
  end

  function automatic bit exp_healthy();
    return m_sw && !(m_ml || m_sl || m_wl || m_ol);
  endfunction
  function automatic bit exp_relay();
    return exp_healthy() && !mo && !so;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R6 healthy", healthy, exp_healthy());
    chk("R10 relay", relay, exp_relay());
    chk("R7 cpu_rst", cpu_rst, m_rleft != 0);
    chk("R3 lamp_fault", lfault, m_ml || m_sl || m_wl || m_ol);
    chk("R9 lamp_off", loff, !m_sw);
  endtask

  task automatic cycle(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      compare_all();
      if (auto_kick) begin
        kick = (kph % 4 == 0);
        kph++;
      end
    end
  endtask

  task automatic press();
    pb = 0; cycle();
    pb = 1; cycle();
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    chk("R1 healthy in reset", healthy, 1'b0);
    chk("R1 lamp_off in reset", loff, 1'b1);
    rst_n = 1;
    cycle();
    chk("R1 healthy", healthy, 1'b0);
    chk("R1 relay", relay, 1'b0);
    chk("R1 cpu_rst", cpu_rst, 1'b0);
    chk("R1 lamp_fault", lfault, 1'b0);
    chk("R1 lamp_off", loff, 1'b1);

    pb = 1; cycle();
    chk("R2 healthy after ON", healthy, 1'b1);
    chk("R2 lamp_off after ON", loff, 1'b0);
    chk("R2 relay after ON", relay, 1'b1);

    mo = 1; #1;
    chk("R10 main open cuts relay", relay, 1'b0);
    chk("R10 health kept", healthy, 1'b1);
    mo = 0; so = 1; #1;
    chk("R10 servo open cuts relay", relay, 1'b0);
    so = 0; #1;
    chk("R10 relay back", relay, 1'b1);

    mf = 1; cycle(CONF - 1); mf = 0; cycle();
    chk("R3 short burst ignored", lfault, 1'b0);
    chk("R3 healthy kept", healthy, 1'b1);
    mf = 1; cycle(CONF);
    chk("R3 confirmed latch", lfault, 1'b1);
    chk("R6 healthy drops", healthy, 1'b0);
    chk("R6 switch forced OFF", loff, 1'b1);
    mf = 0;
    begin
      int hi = 0;
      for (int i = 0; i < RST + 3; i++) begin
        if (cpu_rst) hi++;
        cycle();
      end
      chk("R7 reset pulse length", hi == RST, 1'b1);
    end

    cycle(3);
    chk("R8 held ON does not clear", lfault, 1'b1);
    pb = 0; cycle();
    chk("R8 release does not clear", lfault, 1'b1);
    sf = 1; pb = 1; cycle();
    chk("R8 press with raw fail blocked", lfault, 1'b1);
    chk("R8 still OFF", loff, 1'b1);
    sf = 0; press();
    chk("R8 clean press clears", lfault, 1'b0);
    chk("R8 healthy again", healthy, 1'b1);

    pb = 0; cycle();
    chk("R9 OFF drops healthy", healthy, 1'b0);
    chk("R9 OFF lamp", loff, 1'b1);
    chk("R9 no fault from OFF", lfault, 1'b0);
    pb = 1; cycle();
    chk("R9 ON again", healthy, 1'b1);

    ov = 1; cycle();
    ov = 0;
    chk("R5 overvoltage latched", lfault, 1'b1);
    chk("R5 reset issued", cpu_rst, 1'b1);
    cycle(RST + 2);
    press();
    chk("R5 cleared by press", lfault, 1'b0);

    auto_kick = 0; kick = 0;
    cycle(20); kick = 1; cycle(); kick = 0;
    cycle(20);
    chk("R4 kick restarts window", lfault, 1'b0);
    cycle(11);
    chk("R4 one short of timeout", lfault, 1'b0);
    cycle();
    chk("R4 timeout latched", lfault, 1'b1);
    auto_kick = 1;
    cycle(RST);
    press();
    chk("R4 cleared", healthy, 1'b1);

    auto_kick = 0;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 100 < 8) mf = ~mf;
      if ($urandom % 100 < 8) sf = ~sf;
      ov = ($urandom % 400 == 0);
      kick = ((i / 500) % 3 == 2) ? ($urandom % 50 == 0) : ($urandom % 6 == 0);
      if ($urandom % 100 < 3) pb = ~pb;
      mo = ($urandom % 100 < 5);
      so = ($urandom % 100 < 5);
      cycle();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule